// File: doc/BRIEF.md
# Pipelined Transposed Wavelet Low-Pass FIR

This block filters a stream of signed fixed-point samples with a fixed four-tap low-pass kernel: the decomposition low-pass filter of the second-order Daubechies wavelet. It is built in transposed form. Each accepted sample drives all four constant multipliers in the same cycle. The partial sums travel through a short chain of adders and delay registers.

A register sits at each multiplier output, in front of the adder chain. The longest combinational path is therefore one multiply, and the adder depth does not add to it. The output is rounded back to the input scale, clamped to the sample range and registered. It appears exactly two cycles after the sample that completes it, whatever the tap count. A valid flag follows the data through the same two stages.

An upstream producer drives `in_valid` with `in_data` whenever it has a sample. Cycles without `in_valid` are not counted as samples. They leave both the filter history and the output untouched.

Top module: `wavelet_fir_tr`

## Requirements
- R1: For the accepted sample sequence x[n], each output equals sat(round(Σ c_k·x[n−k])) for k = 0..3. The constants are c0 = −2120, c1 = 3672, c2 = 13705 and c3 = 7913, each scaled by 2^14.
- R2: Input and output samples are 18-bit two's complement with 14 fractional bits. Products and partial sums are kept at full precision until the final rounding.
- R3: The full-precision sum is rounded to the sample scale by adding 2^13 and shifting right arithmetically by 14 bits. Exact halves therefore round toward plus infinity.
- R4: A rounded result above 131071 is output as 131071, and one below −131072 is output as −131072.
- R5: A sample presented with `in_valid` high at one rising edge produces `out_valid` high in the cycle that follows the second rising edge after it. `out_valid` is low in every other cycle.
- R6: While `in_valid` is low, `in_data` is ignored. `out_data` keeps its last value, and the history used by R1 contains only accepted samples.
- R7: A unit impulse (16384) followed by zero samples yields the four constants −2120, 3672, 13705 and 7913 on consecutive outputs, then 0.
- R8: Asserting `rst_n` low clears the history, `out_data` and `out_valid` to zero at once. Release is synchronised to `clk` over two edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | High when `in_data` carries a sample to accept |
| in_data | input | 18 | Input sample, signed, 14 fractional bits |
| out_valid | output | 1 | High for one cycle per filtered output |
| out_data | output | 18 | Filtered sample, signed, 14 fractional bits, rounded and saturated |

## Verification
On every cycle, the assertions check four things: the valid flag moves stage by stage, the output register holds when no result is due, reset leaves the output and flag at zero, and a zero input produces zero products. The numerical behaviour can only be shown by the bench's scenarios. These compare each output with an integer model of the quantised kernel over an impulse, steps at full positive and negative scale, a sweep across the input range, and random traffic with idle gaps. A reset in the middle of a run confirms that no history survives it.

// File: rtl/wfir_pkg.sv
package wfir_pkg;

  // Tap count and coefficient scaling are fixed by the wavelet kernel.
  localparam int NTAPS       = 4;
  localparam int COEF_W      = 18;
  localparam int COEF_FRAC_W = 14;

  // Kernel constants in tap order, rounded to the nearest step of 2^-14.
  function automatic logic signed [COEF_W-1:0] coef_of(input int k);
    logic signed [COEF_W-1:0] c;
    case (k)
      0:       c = -18'sd2120;
      1:       c =  18'sd3672;
      2:       c =  18'sd13705;
      default: c =  18'sd7913;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/wfir_tap_mult.sv
// Constant multipliers, one per tap, each followed by its own product register.
module wfir_tap_mult #(
  parameter int DATA_W = 18,
  parameter int COEF_W = 18,
  parameter int NTAPS  = 4,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [PROD_W-1:0] prod_q [NTAPS]
);

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam logic signed [COEF_W-1:0] COEF = wfir_pkg::coef_of(k);

    logic signed [PROD_W-1:0] prod_d;

    always_comb begin
      prod_d = PROD_W'(sample) * PROD_W'(COEF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q[k] <= '0;
      end else if (en) begin
        prod_q[k] <= prod_d;
      end
    end
  end

endmodule

// File: rtl/wfir_tchain.sv
// Transposed accumulation chain: delay registers hold the partial sums of the later taps.
module wfir_tchain #(
  parameter int PROD_W = 36,
  parameter int ACC_W  = 38,
  parameter int NTAPS  = 4,
  localparam int NDLY  = NTAPS - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [PROD_W-1:0] prod [NTAPS],
  output logic signed [ACC_W-1:0]  sum_full
);

  // Entry j holds the partial sum of taps j+1 .. NTAPS-1.
  logic signed [ACC_W-1:0] part_q [NDLY];
  logic signed [ACC_W-1:0] part_d [NDLY];

  for (genvar j = 0; j < NDLY; j++) begin : g_dly
    if (j == NDLY - 1) begin : g_last
      always_comb begin
        part_d[j] = ACC_W'(prod[j+1]);
      end
    end else begin : g_mid
      always_comb begin
        part_d[j] = ACC_W'(prod[j+1]) + part_q[j+1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        part_q[j] <= '0;
      end else if (en) begin
        part_q[j] <= part_d[j];
      end
    end
  end

  always_comb begin
    sum_full = ACC_W'(prod[0]) + part_q[0];
  end

endmodule

// File: rtl/wfir_round_sat.sv
// Rounds the full-precision sum to the sample scale, clamps it and registers it.
module wfir_round_sat #(
  parameter int ACC_W  = 38,
  parameter int DATA_W = 18,
  parameter int SHIFT  = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [ACC_W-1:0]  sum_full,
  output logic signed [DATA_W-1:0] out_q
);

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MINV = -ACC_W'(64'sd1 <<< (DATA_W - 1));

  logic signed [ACC_W-1:0]  rounded;
  logic signed [DATA_W-1:0] out_d;

  always_comb begin
    rounded = (sum_full + HALF) >>> SHIFT;
    if (rounded > MAXV) begin
      out_d = MAXV[DATA_W-1:0];
    end else if (rounded < MINV) begin
      out_d = MINV[DATA_W-1:0];
    end else begin
      out_d = rounded[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (en) begin
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/wavelet_fir_tr.sv
// Top: reset release synchroniser, valid pipeline, product stage, chain and output stage.
module wavelet_fir_tr #(
  parameter int DATA_W  = 18,
  parameter int GUARD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int NTAPS  = wfir_pkg::NTAPS;
  localparam int COEF_W = wfir_pkg::COEF_W;
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + GUARD_W;

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Valid flags for the product stage and the output stage.
  logic v1_q, v1_d;
  logic v2_q, v2_d;

  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  logic signed [PROD_W-1:0] prod_q [NTAPS];
  logic signed [ACC_W-1:0]  sum_full;
  logic signed [DATA_W-1:0] res_q;

  wfir_tap_mult #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .NTAPS  (NTAPS)
  ) u_mult (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (in_valid),
    .sample ($signed(in_data)),
    .prod_q (prod_q)
  );

  wfir_tchain #(
    .PROD_W (PROD_W),
    .ACC_W  (ACC_W),
    .NTAPS  (NTAPS)
  ) u_chain (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (v1_q),
    .prod     (prod_q),
    .sum_full (sum_full)
  );

  wfir_round_sat #(
    .ACC_W  (ACC_W),
    .DATA_W (DATA_W),
    .SHIFT  (wfir_pkg::COEF_FRAC_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (v1_q),
    .sum_full (sum_full),
    .out_q    (res_q)
  );

  assign out_valid = v2_q;
  assign out_data  = res_q;

endmodule

// File: rtl/wfir_chk.sv
module wfir_chk #(
  parameter int DATA_W = 18,
  parameter int PROD_W = 36,
  parameter int NTAPS  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [DATA_W-1:0]        in_data,
  input logic                     v1,
  input logic                     out_valid,
  input logic [DATA_W-1:0]        out_data,
  input logic signed [PROD_W-1:0] prod [NTAPS]
);

  // R5: an accepted sample raises the first-stage flag one edge later.
  a_r5_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v1);

  // R5: the output flag follows the first-stage flag by exactly one edge.
  a_r5_stage2: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> out_valid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> !out_valid);

  // R6: with no result due, the output holds its value.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(out_data));

  // R8: while reset is applied, the output and its flag read zero.
  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (out_data == '0 && !out_valid));

  // R1: a zero sample gives zero in every product register.
  a_r1_zero_prod: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == '0) |=> (prod[0] == '0 && prod[1] == '0 &&
                                     prod[2] == '0 && prod[3] == '0));

endmodule

bind wavelet_fir_tr wfir_chk #(
  .DATA_W (DATA_W),
  .PROD_W (PROD_W),
  .NTAPS  (NTAPS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .v1        (v1_q),
  .out_valid (out_valid),
  .out_data  (out_data),
  .prod      (prod_q)
);

// File: tb/wavelet_fir_tr_tb.sv
`timescale 1ns/1ps
module wavelet_fir_tr_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [17:0] in_data;
  logic        out_valid;
  logic [17:0] out_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wavelet_fir_tr u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // Model state: accepted history, and expected results for the last two drive slots.
  longint hist [4];
  bit     ev   [2];
  longint ed   [2];
  longint last_out;
  longint coef [4] = '{-2120, 3672, 13705, 7913};

  function automatic longint model_out();
    longint s, r;
    s = 0;
    for (int k = 0; k < 4; k++) s += coef[k] * hist[k];
    r = (s + 64'sd8192) >>> 14;           // R3
    if (r > 131071) r = 131071;           // R4
    if (r < -131072) r = -131072;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 4; k++) hist[k] = 0;
    ev[0] = 0; ev[1] = 0; ed[0] = 0; ed[1] = 0;
    last_out = 0;
  endtask

  // One cycle: check what the outputs show now, then drive the next input.
  task automatic step(input bit v, input longint d, input string req);
    longint act;
    @(negedge clk);
    act = longint'($signed(out_data));
    check(out_valid == ev[1], "R5", longint'(out_valid), longint'(ev[1]));
    if (ev[1]) begin
      check(act == ed[1], req, act, ed[1]);
      last_out = ed[1];
    end else begin
      check(act == last_out, "R6", act, last_out);
    end
    ev[1] = ev[0]; ed[1] = ed[0];
    ev[0] = v;
    if (v) begin
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = d;
      ed[0] = model_out();
    end
    in_valid = v;
    in_data  = v ? d[17:0] : 18'($urandom);   // R6: garbage while invalid
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_clear();
    #1;
    check(out_valid == 1'b0, "R8", longint'(out_valid), 0);
    check(out_data == 18'd0, "R8", longint'($signed(out_data)), 0);
    repeat (3) step(0, 0, "R8");
    rst_n = 1'b1;
    repeat (3) step(0, 0, "R8");
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    model_clear();
    do_reset();

    // R7: impulse response equals the kernel constants.
    step(1, 16384, "R7");
    for (int i = 0; i < 6; i++) step(1, 0, "R7");

    // R1/R2: unit step settles to the DC gain.
    for (int i = 0; i < 8; i++) step(1, 16384, "R1");

    // R4: full-scale steps both ways saturate.
    for (int i = 0; i < 8; i++) step(1, 131071, "R4");
    for (int i = 0; i < 8; i++) step(1, -131072, "R4");
    for (int i = 0; i < 4; i++) step(1, 131071, "R4");

    // R3: small values around the rounding boundaries.
    for (int i = -40; i <= 40; i++) step(1, i * 101, "R3");

    // R2: sweep across the whole input range.
    for (int i = -131072; i <= 131071; i += 257) step(1, i, "R2");

    // R6: random traffic with idle gaps, including extremes.
    for (int i = 0; i < 3000; i++) begin
      int sel;
      longint d;
      sel = $urandom_range(0, 9);
      if (sel == 0)      d = 131071;
      else if (sel == 1) d = -131072;
      else               d = longint'($signed(18'($urandom)));
      step(bit'($urandom_range(0, 1)), d, "R6");
    end
    for (int i = 0; i < 4; i++) step(0, 0, "R6");

    // R8: reset mid-stream, then an impulse must show no old history.
    for (int i = 0; i < 4; i++) step(1, 100000, "R8");
    do_reset();
    step(1, 16384, "R8");
    for (int i = 0; i < 6; i++) step(1, 0, "R8");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule